// File: doc/BRIEF.md
# Pruning-based tree likelihood evaluator

This engine scores one candidate phylogenetic tree against a set of aligned DNA sequences. Before each run, software fills three local stores through a simple write port: a topology table whose records are already in post-order, a branch table with one entry per topology record, and a base store that holds the 2-bit nucleotides of every sequence at every site. Software then sets the record and site counts and pulses `start`. For every site, the engine walks the topology records in table order. Each record becomes a four-entry conditional vector, either one-hot at a leaf or the product of its children's messages. The record's own branch then turns that vector into an upward message under the Jukes-Cantor substitution model. The last record is the root and multiplies three child messages.

The root vector's sum, divided by four, gives the site likelihood. A leading-one detector and a 16-entry mantissa table turn it into a base-2 logarithm. These logarithms are summed into a signed fixed-point log-likelihood, so long alignments cannot underflow. All arithmetic is unsigned Q.15 fixed point (32768 = 1.0); the logarithm uses 8 fraction bits. When the last site has been summed, `result` is loaded and `done` pulses for one cycle.

The control flow has four states. IDLE waits for `start` (transition launch). NODE evaluates one record per cycle and either advances to the next record (step) or, at the last record, latches the site value (site_end to ACCUM). ACCUM adds the site logarithm and either returns to NODE for the next site (next_site) or, after the last site, moves to DONE (finish). DONE drives `done` for one cycle and returns to IDLE (retire).

Top module: `prune_lik_engine`

## Requirements
- R1: While reset is held and directly after it, `busy` and `done` are low and `result` reads 0.
- R2: A `start` sampled in IDLE launches a run. With N records and S sites, `done` is high in the cycle that follows the S·(N+1)-th clock edge after the sampling edge. `busy` stays high from the edge after `start` through the `done` cycle.
- R3: `done` is high for exactly one cycle. `result` takes its new value at the same edge and holds it until the next run's `done`.
- R4: A `start` pulse while `busy` is high has no effect on timing or on the result.
- R5: Writes select their target with `wr_sel`: 0 selects the topology record at `wr_addr[2:0]`, 1 the branch entry at `wr_addr[2:0]`, and 2 the base at sequence `wr_addr[6:4]` and site `wr_addr[3:0]` (data bits [1:0]). A write while `busy` is high is ignored.
- R6: A topology record sits in data bits [12:0]: [12] is the leaf flag, [11:9] the node index, [8:6] the sequence, [5:3] the first child and [2:0] the second child. Child fields name node indices, not record positions, and records are evaluated in table order, from record 0 up to record N-1.
- R7: Bases are coded A=0, C=1, G=2, T=3. At a site, a leaf's vector is 32768 at the position of its base and 0 elsewhere.
- R8: A branch entry holds the same-base probability P_s in bits [31:16] and the changed-base probability P_d in bits [15:0], and it applies to the record at the same position. With vector L and sum S = ΣL, the upward message is m[x] = ((P_s·L[x] + P_d·(S−L[x])) >> 15) mod 2^16. It is stored under the record's node index.
- R9: An internal record's vector is L[x] = ((m_a[x]·m_b[x]) >> 15) mod 2^16. The last record, if internal, then multiplies by a third child whose index is carried in its sequence field, using the same rule.
- R10: The site value is V = (ΣL_root) >> 2. Its contribution is (p−15)·256 + T[k]. Here p is the position of the leading one of V, k is the 4 bits that follow it, and T[k] = round(256·log2(1 + k/16)). A site with V = 0 contributes −4096.
- R11: `result` is the signed 24-bit sum of all site contributions of the run (8 fraction bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store write strobe |
| wr_sel | input | 2 | Write target: topology, branch or base |
| wr_addr | input | 7 | Write address |
| wr_data | input | 32 | Write data |
| start | input | 1 | Launch pulse |
| num_nodes | input | 4 | Number of topology records (1 to 8) |
| num_sites | input | 5 | Number of sites (1 to 16) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 24 | Signed log2 likelihood, 8 fraction bits |

## Verification
Two things can meet in one cycle: a new `start` or store write arriving while a run is still walking its records, and the engine's own stepping through NODE and ACCUM. The bench provokes this by pulsing `start` and, in a separate run, rewriting a base that the running evaluation reads. It then judges the overlap at the ports. The latency must still be S·(N+1)+1 edges, and the result must equal the model's value for the original data. A rerun with no reload must also reproduce that value, which shows the ignored write never reached the store.

// File: rtl/tle_pkg.sv
package tle_pkg;
    localparam int PROB_W   = 16;
    localparam int SUM_W    = PROB_W + 2;
    localparam int LOG_W    = 16;
    localparam int LOG_FRAC = 8;
    localparam logic [PROB_W-1:0] PROB_ONE = 16'h8000;

    typedef logic [PROB_W-1:0] prob_t;
    typedef prob_t [3:0]       pvec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NODE,
        ST_ACCUM,
        ST_DONE
    } tle_state_e;
endpackage

// File: rtl/tle_store.sv
module tle_store #(
    parameter int MAX_NODES = 8,
    parameter int MAX_SITES = 16,
    localparam int NW = $clog2(MAX_NODES),
    localparam int SW = $clog2(MAX_SITES),
    localparam int AW = NW + SW,
    localparam int REC_W = 1 + 4 * NW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       data,
    input  logic [NW-1:0]     rd_rec,
    input  logic [SW-1:0]     rd_site,
    output logic              f_leaf,
    output logic [NW-1:0]     f_idx,
    output logic [NW-1:0]     f_seq,
    output logic [NW-1:0]     f_ca,
    output logic [NW-1:0]     f_cb,
    output logic [15:0]       br_ps,
    output logic [15:0]       br_pd,
    output logic [1:0]        base
);
    logic [REC_W-1:0] topo_mem [MAX_NODES];
    logic [31:0]      br_mem   [MAX_NODES];
    logic [1:0]       base_mem [MAX_NODES * MAX_SITES];
    logic [REC_W-1:0] rec;

    always_ff @(posedge clk) begin
        if (we) begin
            unique case (sel)
                2'd0:    topo_mem[addr[NW-1:0]] <= data[REC_W-1:0];
                2'd1:    br_mem[addr[NW-1:0]]   <= data;
                2'd2:    base_mem[addr]         <= data[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rec    = topo_mem[rd_rec];
        f_leaf = rec[REC_W-1];
        f_idx  = rec[4*NW-1:3*NW];
        f_seq  = rec[3*NW-1:2*NW];
        f_ca   = rec[2*NW-1:NW];
        f_cb   = rec[NW-1:0];
        br_ps  = br_mem[rd_rec][31:16];
        br_pd  = br_mem[rd_rec][15:0];
        base   = base_mem[{f_seq, rd_site}];
    end
endmodule

// File: rtl/tle_node_unit.sv
module tle_node_unit
    import tle_pkg::*;
(
    input  logic         leaf,
    input  logic         root,
    input  logic [1:0]   base,
    input  pvec_t        m_a,
    input  pvec_t        m_b,
    input  pvec_t        m_c,
    input  prob_t        ps,
    input  prob_t        pd,
    output pvec_t        msg,
    output logic [SUM_W-1:0] vsum
);
    pvec_t             lvec;
    logic [31:0]       p_ab [4];
    logic [31:0]       p_c  [4];
    logic [SUM_W-1:0]  diff [4];
    logic [35:0]       mix  [4];

    always_comb begin
        vsum = '0;
        for (int x = 0; x < 4; x++) begin
            p_ab[x] = 32'(m_a[x]) * 32'(m_b[x]);
            p_c[x]  = 32'(prob_t'(p_ab[x] >> 15)) * 32'(m_c[x]);
            if (leaf)
                lvec[x] = (base == 2'(x)) ? PROB_ONE : '0;
            else if (root)
                lvec[x] = prob_t'(p_c[x] >> 15);
            else
                lvec[x] = prob_t'(p_ab[x] >> 15);
            vsum = vsum + SUM_W'(lvec[x]);
        end
        for (int x = 0; x < 4; x++) begin
            diff[x] = vsum - SUM_W'(lvec[x]);
            mix[x]  = 36'(ps) * 36'(lvec[x]) + 36'(pd) * 36'(diff[x]);
            msg[x]  = prob_t'(mix[x] >> 15);
        end
    end
endmodule

// File: rtl/tle_log2.sv
module tle_log2
    import tle_pkg::*;
(
    input  prob_t                   v,
    output logic signed [LOG_W-1:0] contrib
);
    localparam logic [7:0] MANT [16] = '{
        8'd0,   8'd22,  8'd44,  8'd63,  8'd82,  8'd100, 8'd118, 8'd134,
        8'd150, 8'd165, 8'd179, 8'd193, 8'd207, 8'd220, 8'd232, 8'd244
    };

    logic [3:0] lead;
    prob_t      norm;
    logic [3:0] k;

    always_comb begin
        lead = '0;
        for (int i = 0; i < PROB_W; i++)
            if (v[i]) lead = 4'(i);
        norm = prob_t'(v << (4'd15 - lead));
        k    = 4'(norm >> 11);
        if (v == '0)
            contrib = -16'sd4096;
        else
            contrib = $signed({4'd0, lead, 8'd0}) - 16'sd3840
                    + $signed({8'd0, MANT[k]});
    end
endmodule

// File: rtl/prune_lik_engine.sv
module prune_lik_engine
    import tle_pkg::*;
#(
    parameter int MAX_NODES = 8,
    parameter int MAX_SITES = 16,
    parameter int ACC_W     = 24,
    localparam int NW = $clog2(MAX_NODES),
    localparam int SW = $clog2(MAX_SITES),
    localparam int AW = NW + SW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [AW-1:0]           wr_addr,
    input  logic [31:0]             wr_data,
    input  logic                    start,
    input  logic [NW:0]             num_nodes,
    input  logic [SW:0]             num_sites,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] result
);
    tle_state_e state_q, state_d;

    logic [NW-1:0]           rec_q;
    logic [SW-1:0]           site_q;
    logic [NW:0]             nodes_q;
    logic [SW:0]             sites_q;
    prob_t                   vsite_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_next;
    pvec_t                   slots [MAX_NODES];

    logic             f_leaf;
    logic [NW-1:0]    f_idx, f_seq, f_ca, f_cb;
    prob_t            br_ps, br_pd;
    logic [1:0]       base;
    pvec_t            msg;
    logic [SUM_W-1:0] vsum;
    logic signed [LOG_W-1:0] contrib;
    logic             last_rec, last_site, store_we;

    assign store_we  = wr_en && (state_q == ST_IDLE);
    assign last_rec  = ((NW+1)'(rec_q)  == nodes_q - 1'b1);
    assign last_site = ((SW+1)'(site_q) == sites_q - 1'b1);
    assign acc_next  = acc_q + ACC_W'(contrib);

    tle_store #(.MAX_NODES(MAX_NODES), .MAX_SITES(MAX_SITES)) u_store (
        .clk(clk), .we(store_we), .sel(wr_sel), .addr(wr_addr), .data(wr_data),
        .rd_rec(rec_q), .rd_site(site_q),
        .f_leaf(f_leaf), .f_idx(f_idx), .f_seq(f_seq), .f_ca(f_ca), .f_cb(f_cb),
        .br_ps(br_ps), .br_pd(br_pd), .base(base)
    );

    tle_node_unit u_node (
        .leaf(f_leaf), .root(last_rec), .base(base),
        .m_a(slots[f_ca]), .m_b(slots[f_cb]), .m_c(slots[f_seq]),
        .ps(br_ps), .pd(br_pd), .msg(msg), .vsum(vsum)
    );

    tle_log2 u_log (.v(vsite_q), .contrib(contrib));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_NODE;
            ST_NODE:  if (last_rec)  state_d = ST_ACCUM;
            ST_ACCUM: state_d = last_site ? ST_DONE : ST_NODE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q   <= '0;
            site_q  <= '0;
            nodes_q <= '0;
            sites_q <= '0;
            vsite_q <= '0;
            acc_q   <= '0;
            result  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    nodes_q <= num_nodes;
                    sites_q <= num_sites;
                    rec_q   <= '0;
                    site_q  <= '0;
                    acc_q   <= '0;
                end
                ST_NODE: begin
                    if (last_rec) vsite_q <= prob_t'(vsum >> 2);
                    else          rec_q   <= rec_q + 1'b1;
                end
                ST_ACCUM: begin
                    acc_q <= acc_next;
                    if (last_site) begin
                        result <= acc_next;
                    end else begin
                        site_q <= site_q + 1'b1;
                        rec_q  <= '0;
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // per-node message slots, addressed by node index
    always_ff @(posedge clk) begin
        if (state_q == ST_NODE) slots[f_idx] <= msg;
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
    end
endmodule

// File: rtl/prune_lik_engine_chk.sv
module prune_lik_engine_chk #(
    parameter int ACC_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic signed [ACC_W-1:0] result
);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind prune_lik_engine prune_lik_engine_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .result(result)
);

// File: tb/prune_lik_engine_test.sv
module prune_lik_engine_test;
    localparam int NREC = 6;

    typedef struct packed {
        logic [4:0]  ns;
        logic [15:0] ps;
        logic [15:0] pd;
        logic [7:0]  seed;
        logic [1:0]  mul;
        logic        perm;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd4,  16'd32768, 16'd0,    8'h1B, 2'd0, 1'b0},
        '{5'd16, 16'd20480, 16'd4096, 8'hE4, 2'd1, 1'b0},
        '{5'd7,  16'd27853, 16'd1638, 8'h9C, 2'd3, 1'b1},
        '{5'd16, 16'd32768, 16'd0,    8'h1B, 2'd1, 1'b0},
        '{5'd1,  16'd24576, 16'd2731, 8'h00, 2'd2, 1'b1},
        '{5'd12, 16'd16384, 16'd5461, 8'h72, 2'd1, 1'b1}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [6:0]  wr_addr = 0;
    logic [31:0] wr_data = 0;
    logic        start = 0;
    logic [3:0]  num_nodes = 0;
    logic [4:0]  num_sites = 0;
    logic        busy, done;
    logic signed [23:0] result;

    int checks = 0;
    int errors = 0;

    int m_leaf [NREC], m_idx [NREC], m_seq [NREC], m_ca [NREC], m_cb [NREC];
    int m_base [8][16];
    longint m_ps, m_pd;

    always #2 clk = ~clk;

    prune_lik_engine uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .num_nodes(num_nodes), .num_sites(num_sites),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int addr, input longint data);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'(sel); wr_addr = 7'(addr); wr_data = 32'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    function automatic longint log_model(longint v);
        int p = 0;
        longint norm, k, t;
        if (v == 0) return -4096;
        for (int i = 0; i < 16; i++) if (v[i]) p = i;
        norm = (v << (15 - p)) & 65535;
        k = (norm >> 11) & 15;
        t = longint'($rtoi(256.0 * $ln(1.0 + real'(k) / 16.0) / $ln(2.0) + 0.5));
        return (p - 15) * 256 + t;
    endfunction

    function automatic longint model_result(int ns);
        longint acc = 0;
        for (int s = 0; s < ns; s++) begin
            longint slot [8][4];
            longint v = 0;
            for (int r = 0; r < NREC; r++) begin
                longint lv [4];
                longint sm = 0;
                for (int x = 0; x < 4; x++) begin
                    if (m_leaf[r] != 0)
                        lv[x] = (m_base[m_seq[r]][s] == x) ? 32768 : 0;
                    else begin
                        lv[x] = ((slot[m_ca[r]][x] * slot[m_cb[r]][x]) >> 15) & 65535;
                        if (r == NREC - 1)
                            lv[x] = ((lv[x] * slot[m_seq[r]][x]) >> 15) & 65535;
                    end
                    sm += lv[x];
                end
                for (int x = 0; x < 4; x++)
                    slot[m_idx[r]][x] = ((m_ps * lv[x] + m_pd * (sm - lv[x])) >> 15) & 65535;
                if (r == NREC - 1) v = sm >> 2;
            end
            acc += log_model(v);
        end
        return acc;
    endfunction

    task automatic set_rec(input int pos, input int leaf, input int idx,
                           input int sq, input int ca, input int cb);
        m_leaf[pos] = leaf; m_idx[pos] = idx; m_seq[pos] = sq;
        m_ca[pos] = ca; m_cb[pos] = cb;
        wr(0, pos, (leaf << 12) | (idx << 9) | (sq << 6) | (ca << 3) | cb);
    endtask

    task automatic load_case(input vec_t vc);
        int n [NREC];
        for (int p = 0; p < NREC; p++) n[p] = vc.perm ? 7 - p : p;
        set_rec(0, 1, n[0], 0, 0, 0);
        set_rec(1, 1, n[1], 1, 0, 0);
        set_rec(2, 0, n[2], 0, n[0], n[1]);
        set_rec(3, 1, n[3], 2, 0, 0);
        set_rec(4, 1, n[4], 3, 0, 0);
        set_rec(5, 0, n[5], n[4], n[2], n[3]);
        m_ps = longint'(vc.ps); m_pd = longint'(vc.pd);
        for (int p = 0; p < NREC; p++) wr(1, p, {vc.ps, vc.pd});
        for (int sq = 0; sq < 4; sq++)
            for (int st = 0; st < int'(vc.ns); st++) begin
                m_base[sq][st] = (int'(vc.seed) >> (2 * ((sq * int'(vc.mul) + st) % 4))) & 3;
                wr(2, sq * 16 + st, m_base[sq][st]);
            end
        num_nodes = 4'(NREC);
        num_sites = vc.ns;
    endtask

    task automatic run_eval(input int poke_start, input int poke_wr, output int lat);
        lat = 0;
        @(negedge clk);
        start = 1;
        forever begin
            @(negedge clk);
            lat++;
            start = 0; wr_en = 0;
            if (done) break;
            if (lat == poke_start) start = 1;
            if (lat == poke_wr) begin
                wr_en = 1; wr_sel = 2'd2; wr_addr = 7'd0; wr_data = 32'd3;
            end
            if (lat > 4000) begin
                chk("R2 run watchdog", lat, 0);
                break;
            end
        end
    endtask

    task automatic full_case(input int c);
        int lat;
        longint exp;
        load_case(VECS[c]);
        exp = model_result(int'(VECS[c].ns));
        run_eval(-1, -1, lat);
        chk($sformatf("R2 latency case %0d", c), lat, int'(VECS[c].ns) * (NREC + 1) + 1);
        chk($sformatf("R6,R7,R8,R9,R10,R11 result case %0d", c), longint'(result), exp);
        @(negedge clk);
        chk($sformatf("R3 done one cycle case %0d", c), {busy, done}, 0);
    endtask

    initial begin
        #(4 * 200000);
        chk("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        longint exp;

        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 result in reset", result, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done}, 0);

        for (int c = 0; c < 6; c++) full_case(c);

        // R10: identical sequences over zero-length branches give -2.0 per site
        load_case(VECS[0]);
        run_eval(-1, -1, lat);
        chk("R10 identical sites", result, -2048);
        // R10: contradicting bases over zero-length branches give zero sites
        load_case(VECS[3]);
        run_eval(-1, -1, lat);
        chk("R10 zero site floor", result, -65536);

        // R4: start pulse in the middle of a run
        load_case(VECS[1]);
        exp = model_result(int'(VECS[1].ns));
        run_eval(5, -1, lat);
        chk("R4 latency with start while busy", lat, 16 * (NREC + 1) + 1);
        chk("R4 result with start while busy", result, exp);
        @(negedge clk);
        chk("R4 no relaunch", busy, 0);

        // R5: base write while busy must not reach the store
        run_eval(-1, 9, lat);
        chk("R5 result with write while busy", result, exp);
        run_eval(-1, -1, lat);
        chk("R5 rerun after ignored write", result, exp);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule